// File: doc/BRIEF.md
# Hamming Chunk ECC Engine

This block protects a fixed-size chunk of data (512 bytes by default) with a 24-bit single-error-correcting Hamming code. Data arrives one byte per beat. A start pulse clears the parity state before each chunk. Every accepted byte is also written into an attached chunk buffer. The running code is always visible on three byte-wide outputs, and a valid flag rises once the whole chunk has been taken in.

To verify a chunk, the caller presents the three stored code bytes and pulses the check input. The block compares them with the freshly computed code and, one cycle later, reports one of four outcomes:

- the chunk is clean;
- a single data bit was wrong, which the block corrects in the attached buffer and reports as a byte index and a bit mask;
- a single bit of the stored code itself was wrong, so the data is good;
- the error cannot be corrected.

Top module: `hecc_page`

## Requirements
- R1: For each accepted byte at chunk index i (9 bits), each set data bit j forms a 12-bit position p = {i, j}. The upper half H (12 bits) is the XOR of p over all set bits. The lower half L (12 bits) is the XOR of the complement of p over all set bits. The emitted code is the bitwise inverse of {H, L}, with H in bits 23:12.
- R2: The code byte outputs are least significant first: code_b0 carries bits 7:0, code_b1 bits 15:8 and code_b2 bits 23:16. The stored code inputs ref_b0..ref_b2 use the same order.
- R3: A chunk of all 0xFF bytes produces the code 0xFFFFFF, and checking it against stored bytes FF FF FF reports clean.
- R4: A start pulse clears the parity and the beat count on the next edge, so the code reads 0xFFFFFF and code_valid is low. A beat offered in the same cycle as start is dropped. code_valid rises after exactly CHUNK_BYTES accepted beats, and further beats are ignored until the next start.
- R5: done is high for exactly the cycle after each cycle in which check is high. status is coded as 0 clean, 1 data bit corrected, 2 error in code only, 3 uncorrectable.
- R6: When the stored and computed codes are equal (difference d = 0), status is 0.
- R7: When the upper half of d XOR the lower half of d equals 0xFFF and d[23:15] < CHUNK_BYTES, status is 1. fix_index is d[23:15], fix_mask is 1 << d[14:12], and that buffer byte is inverted at the mask on the same edge that raises done.
- R8: When the halves of d fold to 0xFFF but d[23:15] >= CHUNK_BYTES, status is 3 and the buffer is not changed.
- R9: When d has exactly one bit set, status is 2 and the buffer is not changed.
- R10: Any other nonzero d gives status 3.
- R11: fix_count is 1 when status is 1 or 2, and 0 when status is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear parity and beat count |
| in_valid | input | 1 | Data beat present |
| in_data | input | 8 | Data byte |
| code_b0 | output | 8 | Code bits 7:0 |
| code_b1 | output | 8 | Code bits 15:8 |
| code_b2 | output | 8 | Code bits 23:16 |
| code_valid | output | 1 | Whole chunk accumulated |
| check | input | 1 | Compare the stored code with the computed code |
| ref_b0 | input | 8 | Stored code bits 7:0 |
| ref_b1 | input | 8 | Stored code bits 15:8 |
| ref_b2 | input | 8 | Stored code bits 23:16 |
| done | output | 1 | Check result valid |
| status | output | 2 | Check outcome |
| fix_index | output | 9 | Byte index to correct |
| fix_mask | output | 8 | Bit mask to correct |
| fix_count | output | 1 | One error handled |
| rd_addr | input | 9 | Chunk buffer read index |
| rd_data | output | 8 | Chunk buffer byte (0 out of range) |

## Verification
The hardest case to reach is the correctable pattern whose byte index lies beyond the chunk. Real data can never produce it, because every index of a streamed chunk is in range. The bench therefore runs with a 256-byte chunk and builds the stored code as the computed code XOR {p, ~p}, with p naming byte 300. It then reads buffer entry 44 (300 modulo 256) to show that no truncated index slipped through and changed the data. The correctable path is reached by streaming a chunk with one bit flipped and checking it against the code of the unflipped data.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int POS_W  = 12;
  localparam int CODE_W = 2 * POS_W;
  localparam int IDX_W  = 9;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_BAD   = 2'd3
  } hecc_status_e;

  typedef struct packed {
    hecc_status_e        st;
    logic [IDX_W-1:0]    idx;
    logic [7:0]          mask;
    logic                cnt;
  } hecc_result_t;
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat_valid,
  input  logic [7:0]        beat_data,
  output logic [POS_W-1:0]  par_hi,
  output logic [POS_W-1:0]  par_lo,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              take,
  output logic              full
);
  localparam int CNT_W = $clog2(CHUNK_BYTES + 1);

  logic [POS_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [CODE_W-1:0] byte_parity(input logic [IDX_W-1:0] idx,
                                                    input logic [7:0] d);
    logic [POS_W-1:0] h, l, p;
    h = '0;
    l = '0;
    for (int j = 0; j < 8; j++) begin
      p = {idx, 3'(j)};
      if (d[j]) begin
        h = h ^ p;
        l = l ^ ~p;
      end
    end
    return {h, l};
  endfunction

  assign full   = (cnt_q == CNT_W'(CHUNK_BYTES));
  assign take   = beat_valid && !start && !full;
  assign wr_idx = IDX_W'(cnt_q);

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    cnt_d = cnt_q;
    if (start) begin
      hi_d  = '0;
      lo_d  = '0;
      cnt_d = '0;
    end else if (take) begin
      {hi_d, lo_d} = {hi_q, lo_q} ^ byte_parity(wr_idx, beat_data);
      cnt_d        = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      cnt_q <= cnt_d;
    end
  end

  assign par_hi = hi_q;
  assign par_lo = lo_q;
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output hecc_result_t      res
);
  logic [CODE_W-1:0] diff;
  logic [POS_W-1:0]  fold;
  logic [IDX_W-1:0]  idx;
  logic              in_range;

  assign diff     = calc_code ^ stored_code;
  assign fold     = diff[CODE_W-1:POS_W] ^ diff[POS_W-1:0];
  assign idx      = diff[CODE_W-1:POS_W+3];
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(CHUNK_BYTES));

  always_comb begin
    res.st   = ST_BAD;
    res.idx  = '0;
    res.mask = '0;
    res.cnt  = 1'b0;
    if (diff == '0) begin
      res.st = ST_CLEAN;
    end else if (fold == '1) begin
      if (in_range) begin
        res.st   = ST_FIXED;
        res.idx  = idx;
        res.mask = 8'(1) << diff[POS_W+2:POS_W];
        res.cnt  = 1'b1;
      end
    end else if ($onehot(diff)) begin
      res.st  = ST_CODE;
      res.cnt = 1'b1;
    end
  end
endmodule

// File: rtl/hecc_chunk_buf.sv
module hecc_chunk_buf
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             fix_en,
  input  logic [IDX_W-1:0] fix_idx,
  input  logic [7:0]       fix_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int AW = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;

  logic [7:0] mem [CHUNK_BYTES];

  always_ff @(posedge clk) begin
    for (int e = 0; e < CHUNK_BYTES; e++) begin
      if (wr_en && (wr_idx == IDX_W'(e))) begin
        mem[e] <= wr_data;
      end else if (fix_en && (fix_idx == IDX_W'(e))) begin
        mem[e] <= mem[e] ^ fix_mask;
      end
    end
  end

  always_comb begin
    if ({1'b0, rd_idx} < (IDX_W+1)'(CHUNK_BYTES)) begin
      rd_data = mem[AW'(rd_idx)];
    end else begin
      rd_data = '0;
    end
  end
endmodule

// File: rtl/hecc_page.sv
module hecc_page
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic [7:0] code_b0,
  output logic [7:0] code_b1,
  output logic [7:0] code_b2,
  output logic       code_valid,
  input  logic       check,
  input  logic [7:0] ref_b0,
  input  logic [7:0] ref_b1,
  input  logic [7:0] ref_b2,
  output logic       done,
  output logic [1:0] status,
  output logic [8:0] fix_index,
  output logic [7:0] fix_mask,
  output logic       fix_count,
  input  logic [8:0] rd_addr,
  output logic [7:0] rd_data
);
  logic [POS_W-1:0]  par_hi, par_lo;
  logic [IDX_W-1:0]  wr_idx;
  logic              take;
  logic [CODE_W-1:0] calc_code;
  hecc_result_t      res;
  logic              fix_en;

  logic              done_q, done_d;
  hecc_status_e      st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [7:0]        mask_q, mask_d;
  logic              cnt_q, cnt_d;

  hecc_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_accum (
    .clk(clk), .rst_n(rst_n), .start(start),
    .beat_valid(in_valid), .beat_data(in_data),
    .par_hi(par_hi), .par_lo(par_lo),
    .wr_idx(wr_idx), .take(take), .full(code_valid)
  );

  assign calc_code = ~{par_hi, par_lo};
  assign {code_b2, code_b1, code_b0} = calc_code;

  hecc_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_class (
    .calc_code(calc_code),
    .stored_code({ref_b2, ref_b1, ref_b0}),
    .res(res)
  );

  assign fix_en = check && (res.st == ST_FIXED);

  hecc_chunk_buf #(.CHUNK_BYTES(CHUNK_BYTES)) u_buf (
    .clk(clk),
    .wr_en(take), .wr_idx(wr_idx), .wr_data(in_data),
    .fix_en(fix_en), .fix_idx(res.idx), .fix_mask(res.mask),
    .rd_idx(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    done_d = check;
    st_d   = st_q;
    idx_d  = idx_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (check) begin
      st_d   = res.st;
      idx_d  = res.idx;
      mask_d = res.mask;
      cnt_d  = res.cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      st_q   <= ST_CLEAN;
      idx_q  <= '0;
      mask_q <= '0;
      cnt_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      st_q   <= st_d;
      idx_q  <= idx_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign done      = done_q;
  assign status    = st_q;
  assign fix_index = idx_q;
  assign fix_mask  = mask_q;
  assign fix_count = cnt_q;
endmodule

// File: rtl/hecc_page_chk.sv
module hecc_page_chk #(
  parameter int CHUNK_BYTES = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       check,
  input logic [7:0] code_b0,
  input logic [7:0] code_b1,
  input logic [7:0] code_b2,
  input logic [7:0] ref_b0,
  input logic [7:0] ref_b1,
  input logic [7:0] ref_b2,
  input logic       code_valid,
  input logic       done,
  input logic [1:0] status,
  input logic [8:0] fix_index,
  input logic [7:0] fix_mask,
  input logic       fix_count
);
  // R5
  done_follows_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check |=> done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !check |=> !done);

  // R4
  start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!code_valid && {code_b2, code_b1, code_b0} == 24'hFFFFFF));

  // R6
  equal_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check && {ref_b2, ref_b1, ref_b0} == {code_b2, code_b1, code_b0}) |=> (status == 2'd0));

  // R7
  fix_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> ($onehot(fix_mask) && ({1'b0, fix_index} < 10'(CHUNK_BYTES))));

  // R11
  fix_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_count == (status == 2'd1 || status == 2'd2)));
endmodule

bind hecc_page hecc_page_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .check(check),
  .code_b0(code_b0), .code_b1(code_b1), .code_b2(code_b2),
  .ref_b0(ref_b0), .ref_b1(ref_b1), .ref_b2(ref_b2),
  .code_valid(code_valid), .done(done), .status(status),
  .fix_index(fix_index), .fix_mask(fix_mask), .fix_count(fix_count)
);

// File: tb/sim_hecc_page.sv
module sim_hecc_page;
  localparam int CH = 256;

  logic       clk = 1'b0;
  logic       rst_n, start, in_valid, check;
  logic [7:0] in_data, ref_b0, ref_b1, ref_b2;
  logic [7:0] code_b0, code_b1, code_b2, fix_mask, rd_data;
  logic       code_valid, done, fix_count;
  logic [1:0] status;
  logic [8:0] fix_index, rd_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hecc_page #(.CHUNK_BYTES(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .code_b0(code_b0), .code_b1(code_b1), .code_b2(code_b2), .code_valid(code_valid),
    .check(check), .ref_b0(ref_b0), .ref_b1(ref_b1), .ref_b2(ref_b2),
    .done(done), .status(status), .fix_index(fix_index), .fix_mask(fix_mask),
    .fix_count(fix_count), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  logic [11:0] m_hi, m_lo;
  int          m_cnt;
  logic [7:0]  m_mem [CH];
  logic        e_done;
  int          e_st, e_idx;
  logic [7:0]  e_mask;
  logic        e_cnt;
  logic [7:0]  pat [CH];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] calc_code(input logic [7:0] arr [CH], input int n);
    int h = 0;
    int l = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        if (arr[i][j]) begin
          h = h ^ (i * 8 + j);
          l = l ^ (4095 - (i * 8 + j));
        end
    return ~24'(h * 4096 + l);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_cnt = 0; e_done = 0;
    end else begin
      logic [23:0] ec, d;
      e_done = check;
      if (check) begin
        ec = ~{m_hi, m_lo};
        d = ec ^ {ref_b2, ref_b1, ref_b0};
        e_cnt = 0; e_mask = 0; e_idx = 0;
        if (d == 0) e_st = 0;
        else if ((d[23:12] ^ d[11:0]) == 12'hFFF) begin
          if (int'(d >> 15) < CH) begin
            e_st = 1; e_idx = int'(d >> 15); e_mask = 8'(1 << d[14:12]); e_cnt = 1;
            m_mem[e_idx] = m_mem[e_idx] ^ e_mask;
          end else e_st = 3;
        end else if ((d & (d - 1)) == 0) begin
          e_st = 2; e_cnt = 1;
        end else e_st = 3;
      end
      if (start) begin
        m_hi = 0; m_lo = 0; m_cnt = 0;
      end else if (in_valid && m_cnt < CH) begin
        for (int j = 0; j < 8; j++)
          if (in_data[j]) begin
            m_hi = m_hi ^ 12'(m_cnt * 8 + j);
            m_lo = m_lo ^ ~12'(m_cnt * 8 + j);
          end
        m_mem[m_cnt] = in_data;
        m_cnt++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({code_b2, code_b1, code_b0} == ~{m_hi, m_lo}, "R1 R2 code",
          32'({code_b2, code_b1, code_b0}), 32'(~{m_hi, m_lo}));
      chk(code_valid == (m_cnt == CH), "R4 code_valid", 32'(code_valid), 32'(m_cnt == CH));
      chk(done == e_done, "R5 done", 32'(done), 32'(e_done));
      if (e_done) begin
        chk(int'(status) == e_st,
            e_st == 0 ? "R6 status" : e_st == 1 ? "R7 status" : e_st == 2 ? "R9 status" : "R10 status",
            32'(status), 32'(e_st));
        chk(fix_count == e_cnt, "R11 fix_count", 32'(fix_count), 32'(e_cnt));
        if (e_st == 1) begin
          chk(int'(fix_index) == e_idx, "R7 fix_index", 32'(fix_index), 32'(e_idx));
          chk(fix_mask == e_mask, "R7 fix_mask", 32'(fix_mask), 32'(e_mask));
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_check(input logic [23:0] c);
    {ref_b2, ref_b1, ref_b0} = c;
    check = 1'b1;
    @(negedge clk);
    check = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
    rd_addr = 9'(a);
    #1;
    chk(rd_data == exp, tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [23:0] c, gold;
    rst_n = 1'b0; start = 0; in_valid = 0; check = 0; in_data = 0;
    ref_b0 = 0; ref_b1 = 0; ref_b2 = 0; rd_addr = 0;
    for (int i = 0; i < CH; i++) pat[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk(!code_valid && !done && {code_b2, code_b1, code_b0} == 24'hFFFFFF, "R4 reset",
        32'({code_valid, done, code_b2, code_b1, code_b0}), 32'h00FFFFFF);

    // R3 erased chunk; R4 beat alongside start dropped, excess beats ignored
    start = 1'b1; in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < CH + 4; i++) send(8'hFF);
    chk(code_valid, "R4 full", 32'(code_valid), 32'd1);
    chk({code_b2, code_b1, code_b0} == 24'hFFFFFF, "R3 erased code",
        32'({code_b2, code_b1, code_b0}), 32'hFFFFFF);
    do_check(24'hFFFFFF);
    chk(status == 2'd0, "R3 erased clean", 32'(status), 32'd0);

    // R1 R2 patterned chunk against independent code, then R6 and R9
    pulse_start();
    for (int i = 0; i < CH; i++) send(pat[i]);
    gold = calc_code(pat, CH);
    c = {code_b2, code_b1, code_b0};
    chk(c == gold, "R1 pattern code", 32'(c), 32'(gold));
    chk(code_b0 == gold[7:0] && code_b2 == gold[23:16], "R2 byte order",
        32'({code_b2, code_b0}), 32'({gold[23:16], gold[7:0]}));
    do_check(gold);
    chk(status == 2'd0, "R6 clean", 32'(status), 32'd0);
    do_check(gold ^ 24'h000400);
    chk(status == 2'd2 && fix_count, "R9 code only", 32'({fix_count, status}), 32'h6);
    rd_chk(5, pat[5], "R9 data untouched");

    // R7 single data bit flipped at byte 37 bit 5
    pulse_start();
    for (int i = 0; i < CH; i++) send(i == 37 ? pat[i] ^ 8'h20 : pat[i]);
    do_check(gold);
    chk(status == 2'd1 && fix_index == 9'd37 && fix_mask == 8'h20, "R7 correct",
        32'({status, fix_index, fix_mask}), 32'({2'd1, 9'd37, 8'h20}));
    rd_chk(37, pat[37], "R7 buffer fixed");

    // R8 folded pattern naming byte 300 (beyond chunk)
    c = {code_b2, code_b1, code_b0};
    do_check(c ^ {12'd2402, ~12'd2402});
    chk(status == 2'd3 && !fix_count, "R8 out of range", 32'({fix_count, status}), 32'd3);
    rd_chk(44, pat[44], "R8 buffer untouched");
    rd_chk(37, pat[37], "R8 buffer untouched");

    // R10 two-bit difference
    do_check(c ^ 24'h000003);
    chk(status == 2'd3 && !fix_count, "R10 uncorrectable", 32'({fix_count, status}), 32'd3);

    // R10 wide difference
    do_check(c ^ 24'h0F00F0);
    chk(status == 2'd3, "R10 uncorrectable wide", 32'(status), 32'd3);

    @(negedge clk);
    chk(!done, "R5 done drops", 32'(done), 32'd0);
    finish_run();
  end
endmodule